// File: doc/BRIEF.md
# SONET Frame and Byte Aligner

This block hunts for the SONET framing word in a bit-serial STS-3 or STS-12 stream and marks where bytes and frames begin. Each clock it may take one serial bit, qualified by a valid strobe. The bit comes from either the received line or the looped-back transmit stream, as chosen by a diagnostic loopback select. Two single-cycle outputs come out: a byte strobe that tells a downstream deserializer when eight bits form a byte, and a frame pulse that marks the end of the framing word.

An out-of-frame control input governs the hunt. A rising edge on that input arms it, and it stays armed while the input is high. Once the input drops, the first framing match seen disarms it. While armed, a match at any bit offset moves the byte boundary. While disarmed, the boundary is frozen, and only a match that ends on that boundary raises the frame pulse. Overhead checking, descrambling and clock recovery belong to other blocks.

Top module: `frame_aligner`

## Requirements
- R1: The framing word is 48 bits: three bytes of 8'hF6 and then three bytes of 8'h28, each received most significant bit first. A word with any one bit changed is not a match.
- R2: After reset both outputs are low and the hunt is disarmed. The byte phase starts at zero, so the first byte strobe follows the eighth valid bit.
- R3: A rising edge on `oof` arms the hunt from the next clock. While `oof` stays high, every match at any offset raises the frame pulse and moves the byte boundary to the bit that completed the match.
- R4: After `oof` falls, the hunt stays armed until the next match. That match raises the frame pulse, moves the boundary and disarms the hunt.
- R5: While disarmed, a match that does not end on the current byte boundary raises no frame pulse and leaves the byte strobe phase unchanged.
- R6: While disarmed, a match whose last bit is the last bit of a byte raises the frame pulse.
- R7: The byte strobe marks every eighth valid bit after the last boundary. Cycles with `bit_vld` low do not advance the phase.
- R8: With `loop_en` high only `loop_bit` is searched. With it low only `line_bit` is searched.
- R9: The frame pulse and the byte strobe are each high for exactly one clock: the clock after the valid cycle that carried the completing bit. The frame pulse is always accompanied by a byte strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_bit | input | 1 | Serial bit from the line receiver |
| loop_bit | input | 1 | Serial bit looped back from the transmitter |
| loop_en | input | 1 | High selects `loop_bit` as the searched source |
| bit_vld | input | 1 | The selected serial bit is valid this clock |
| oof | input | 1 | Out-of-frame control; a rising edge arms the hunt |
| byte_strobe | output | 1 | One-clock marker of a completed byte |
| frame_pulse | output | 1 | One-clock marker of a completed framing word |

## Verification
The assertions assume that `oof` is a level held for at least one clock and that it is sampled on every clock, whether or not `bit_vld` is high. They also assume that the selected bit is only meaningful when `bit_vld` is high. The stimulus changes `oof` only in cycles with `bit_vld` low and drives inputs on the falling edge. It places framing words at chosen phases relative to the bench's own byte count, so that the aligned and misaligned cases each occur on purpose. The filler bits between words come from a long bench LFSR, so they make an accidental framing word very unlikely.

// File: rtl/fa_pkg.sv
package fa_pkg;
  typedef enum logic {
    FA_SRC_LINE = 1'b0,
    FA_SRC_LOOP = 1'b1
  } fa_src_e;

  typedef struct packed {
    logic strobe;
    logic pulse;
  } fa_marks_t;
endpackage

// File: rtl/fa_src_sel.sv
module fa_src_sel
  import fa_pkg::*;
(
  input  logic line_bit,
  input  logic loop_bit,
  input  logic loop_en,
  output logic sel_bit
);
  fa_src_e src;

  always_comb begin
    src     = loop_en ? FA_SRC_LOOP : FA_SRC_LINE;
    sel_bit = (src == FA_SRC_LOOP) ? loop_bit : line_bit;
  end
endmodule

// File: rtl/fa_window.sv
module fa_window #(
  parameter int unsigned BYTE_W = 8,
  parameter int unsigned REP    = 3,
  parameter logic [BYTE_W-1:0] HEAD = 8'hF6,
  parameter logic [BYTE_W-1:0] TAIL = 8'h28
) (
  input  logic clk,
  input  logic rst_n,
  input  logic vld,
  input  logic din,
  output logic hit
);
  localparam int unsigned WIN_W = 2 * REP * BYTE_W;

  function automatic logic [WIN_W-1:0] build_word();
    logic [WIN_W-1:0] w;
    w = '0;
    for (int i = 0; i < 2 * REP; i++) begin
      w[WIN_W-1-i*BYTE_W -: BYTE_W] = (i < REP) ? HEAD : TAIL;
    end
    return w;
  endfunction

  function automatic logic [WIN_W-1:0] shift_in(logic [WIN_W-1:0] w, logic b);
    return {w[WIN_W-2:0], b};
  endfunction

  localparam logic [WIN_W-1:0] WORD = build_word();

  logic [WIN_W-1:0] win_q;
  logic [WIN_W-1:0] win_nx;

  always_comb begin
    win_nx = shift_in(win_q, din);
    hit    = (win_nx == WORD);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) win_q <= '0;
    else if (vld) win_q <= win_nx;
  end

  // R7: history moves only on valid bits
  assert_win_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !vld |=> $stable(win_q));
endmodule

// File: rtl/fa_arm_ctl.sv
module fa_arm_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic oof,
  input  logic match_vld,
  output logic armed,
  output logic arm_rise
);
  logic oof_q;
  logic disarm;
  logic armed_nx;

  always_comb begin
    arm_rise = oof & ~oof_q;
    disarm   = armed & ~oof & match_vld;
    if (arm_rise)    armed_nx = 1'b1;
    else if (disarm) armed_nx = 1'b0;
    else             armed_nx = armed;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      oof_q <= 1'b0;
      armed <= 1'b0;
    end else begin
      oof_q <= oof;
      armed <= armed_nx;
    end
  end

  // R3: armed hunt survives while oof is high
  assert_arm_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && oof) |=> armed);
  // R3: arming comes only from an oof rising edge
  assert_arm_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(armed) |-> $past(arm_rise));
  // R4: disarming comes only from a match with oof low
  assert_disarm_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(armed) |-> $past(match_vld && !oof));
endmodule

// File: rtl/fa_phase.sv
module fa_phase #(
  parameter int unsigned BYTE_W = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic vld,
  input  logic realign,
  output logic on_last
);
  localparam int unsigned CNT_W = (BYTE_W > 1) ? $clog2(BYTE_W) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(BYTE_W - 1);

  function automatic logic [CNT_W-1:0] step(logic [CNT_W-1:0] c);
    return (c == LAST) ? '0 : c + 1'b1;
  endfunction

  logic [CNT_W-1:0] cnt;

  assign on_last = (cnt == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n)       cnt <= '0;
    else if (realign) cnt <= '0;
    else if (vld)     cnt <= step(cnt);
  end

  // R7: idle cycles leave the phase alone
  assert_phase_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!vld && !realign) |=> $stable(cnt));
  // R3: a realignment restarts the byte count
  assert_phase_restart_R3: assert property (@(posedge clk) disable iff (!rst_n)
    realign |=> (cnt == '0));
  // R7: mid-byte valid bits advance the phase by one
  assert_phase_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (vld && !realign && !on_last) |=> (cnt == $past(cnt) + 1'b1));
endmodule

// File: rtl/frame_aligner.sv
module frame_aligner
  import fa_pkg::*;
#(
  parameter int unsigned BYTE_W = 8,
  parameter int unsigned REP    = 3,
  parameter logic [BYTE_W-1:0] HEAD = 8'hF6,
  parameter logic [BYTE_W-1:0] TAIL = 8'h28
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_bit,
  input  logic loop_bit,
  input  logic loop_en,
  input  logic bit_vld,
  input  logic oof,
  output logic byte_strobe,
  output logic frame_pulse
);
  logic      sel_bit;
  logic      hit;
  logic      match_vld;
  logic      armed;
  logic      arm_rise;
  logic      on_last;
  logic      realign;
  logic      aligned_hit;
  fa_marks_t marks_d;
  fa_marks_t marks_q;

  fa_src_sel u_src (
    .line_bit (line_bit),
    .loop_bit (loop_bit),
    .loop_en  (loop_en),
    .sel_bit  (sel_bit)
  );

  fa_window #(.BYTE_W(BYTE_W), .REP(REP), .HEAD(HEAD), .TAIL(TAIL)) u_win (
    .clk   (clk),
    .rst_n (rst_n),
    .vld   (bit_vld),
    .din   (sel_bit),
    .hit   (hit)
  );

  fa_arm_ctl u_arm (
    .clk       (clk),
    .rst_n     (rst_n),
    .oof       (oof),
    .match_vld (match_vld),
    .armed     (armed),
    .arm_rise  (arm_rise)
  );

  fa_phase #(.BYTE_W(BYTE_W)) u_phase (
    .clk     (clk),
    .rst_n   (rst_n),
    .vld     (bit_vld),
    .realign (realign),
    .on_last (on_last)
  );

  always_comb begin
    match_vld      = bit_vld & hit;
    realign        = match_vld & armed;
    aligned_hit    = match_vld & on_last;
    marks_d.pulse  = realign | aligned_hit;
    marks_d.strobe = bit_vld & (realign | on_last);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) marks_q <= '0;
    else        marks_q <= marks_d;
  end

  assign byte_strobe = marks_q.strobe;
  assign frame_pulse = marks_q.pulse;

  // R9: a frame pulse always lands on a byte boundary
  assert_pulse_on_byte_R9: assert property (@(posedge clk) disable iff (!rst_n)
    frame_pulse |-> byte_strobe);
  // R7: a byte strobe follows a valid bit
  assert_strobe_needs_bit_R7: assert property (@(posedge clk) disable iff (!rst_n)
    byte_strobe |-> $past(bit_vld));
  // R5: a misaligned match while disarmed stays silent
  assert_frozen_silent_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (match_vld && !armed && !on_last) |=> !frame_pulse);
  // R4: an armed match with oof low leaves the hunt disarmed
  assert_one_shot_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (realign && !oof && !arm_rise) |=> !armed);
endmodule

// File: tb/frame_aligner_tb.sv
`timescale 1ns/1ps
module frame_aligner_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic line_bit = 1'b0, loop_bit = 1'b0, loop_en = 1'b0, bit_vld = 1'b0, oof = 1'b0;
  logic byte_strobe, frame_pulse;

  always #2.5 clk = ~clk;

  frame_aligner u_dut (
    .clk(clk), .rst_n(rst_n), .line_bit(line_bit), .loop_bit(loop_bit),
    .loop_en(loop_en), .bit_vld(bit_vld), .oof(oof),
    .byte_strobe(byte_strobe), .frame_pulse(frame_pulse)
  );

  typedef struct {
    logic  st;
    logic  fp;
    string tag;
  } item_t;
  item_t q[$];

  int n_checks = 0, n_fails = 0, pulses_seen = 0;
  bit done = 1'b0;
  string cur_tag = "R2";

  // independent reference state
  logic [47:0] m_hist = '0;
  int  m_count = 0;
  bit  m_armed = 1'b0;
  bit  m_oof_prev = 1'b0;
  logic [31:0] lfsr = 32'h1ACE_B00C;

  function automatic logic [47:0] word48();
    return {8'hF6, 8'hF6, 8'hF6, 8'h28, 8'h28, 8'h28};
  endfunction

  task automatic check(string tag, logic act, logic exp, string what);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s %s actual=%b expected=%b", tag, what, act, exp);
    end
  endtask

  task automatic check_int(string tag, int act, int exp, string what);
    n_checks++;
    if (act != exp) begin
      n_fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // driver: one clock of stimulus, expectation pushed after the edge
  task automatic cycle(bit v, bit lb, bit pb, bit le, bit o);
    item_t it;
    bit src, hit;
    @(negedge clk);
    bit_vld = v; line_bit = lb; loop_bit = pb; loop_en = le; oof = o;
    it.st = 1'b0; it.fp = 1'b0; it.tag = cur_tag;
    src = le ? pb : lb;
    hit = 1'b0;
    if (v) begin
      m_hist = {m_hist[46:0], src};
      hit = (m_hist == word48());
      if (m_armed && hit) begin
        it.st = 1'b1; it.fp = 1'b1; m_count = 0;
      end else begin
        m_count++;
        if (m_count == 8) begin
          it.st = 1'b1; it.fp = hit; m_count = 0;
        end
      end
    end
    if (o && !m_oof_prev) m_armed = 1'b1;
    else if (m_armed && !o && hit) m_armed = 1'b0;
    m_oof_prev = o;
    @(posedge clk);
    q.push_back(it);
  endtask

  function automatic bit rnd();
    lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
    return lfsr[0];
  endfunction

  task automatic line(bit b);
    cycle(1'b1, b, rnd(), loop_en, oof);
  endtask

  task automatic idle();
    cycle(1'b0, rnd(), rnd(), loop_en, oof);
  endtask

  task automatic set_oof(bit o);
    cycle(1'b0, rnd(), rnd(), loop_en, o);
  endtask

  task automatic send_word(logic [47:0] w);
    for (int i = 47; i >= 0; i--) line(w[i]);
  endtask

  task automatic pad_to(int target);
    while (m_count != target) line(rnd());
  endtask

  // monitor
  initial begin
    item_t it;
    forever begin
      @(negedge clk);
      while (q.size() > 0) begin
        it = q.pop_front();
        check(it.tag, byte_strobe, it.st, "byte_strobe");
        check(it.tag, frame_pulse, it.fp, "frame_pulse");
        if (frame_pulse === 1'b1) pulses_seen++;
      end
    end
  end

  initial begin
    #400000;
    if (!done) begin
      n_fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    int p0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R2", byte_strobe, 1'b0, "strobe after reset");
    check("R2", frame_pulse, 1'b0, "pulse after reset");

    cur_tag = "R2";
    for (int i = 0; i < 16; i++) line(rnd());

    cur_tag = "R7";
    for (int i = 0; i < 20; i++) begin
      line(rnd());
      if (i % 3 == 0) idle();
    end

    cur_tag = "R5";
    p0 = pulses_seen;
    pad_to(3);
    send_word(word48());
    for (int i = 0; i < 12; i++) line(rnd());
    #1;
    check_int("R5", pulses_seen - p0, 0, "pulses from misaligned frozen match");

    cur_tag = "R6";
    p0 = pulses_seen;
    pad_to(0);
    send_word(word48());
    for (int i = 0; i < 10; i++) line(rnd());
    #1;
    check_int("R6", pulses_seen - p0, 1, "pulses from aligned frozen match");

    cur_tag = "R3";
    set_oof(1'b1);
    p0 = pulses_seen;
    pad_to(5);
    send_word(word48());
    for (int i = 0; i < 3; i++) line(rnd());
    send_word(word48());
    for (int i = 0; i < 13; i++) line(rnd());
    #1;
    check_int("R3", pulses_seen - p0, 2, "pulses while oof high");

    cur_tag = "R1";
    p0 = pulses_seen;
    send_word(word48() ^ 48'h0000_0100_0000);
    for (int i = 0; i < 5; i++) line(rnd());
    send_word(word48() ^ 48'h0000_0000_0001);
    for (int i = 0; i < 9; i++) line(rnd());
    #1;
    check_int("R1", pulses_seen - p0, 0, "pulses from damaged words");

    cur_tag = "R4";
    set_oof(1'b0);
    idle();
    p0 = pulses_seen;
    pad_to(6);
    send_word(word48());
    for (int i = 0; i < 3; i++) line(rnd());
    send_word(word48());
    for (int i = 0; i < 11; i++) line(rnd());
    #1;
    check_int("R4", pulses_seen - p0, 1, "only first match after oof fell");

    cur_tag = "R8";
    loop_en = 1'b1;
    set_oof(1'b1);
    p0 = pulses_seen;
    pad_to(2);
    for (int i = 47; i >= 0; i--) cycle(1'b1, rnd(), word48()>>i, 1'b1, 1'b1);
    for (int i = 0; i < 7; i++) line(rnd());
    for (int i = 47; i >= 0; i--) cycle(1'b1, word48()>>i, rnd(), 1'b1, 1'b1);
    for (int i = 0; i < 9; i++) line(rnd());
    #1;
    check_int("R8", pulses_seen - p0, 1, "only looped source searched");
    loop_en = 1'b0;
    set_oof(1'b0);

    cur_tag = "R9";
    for (int i = 0; i < 24; i++) begin
      line(rnd());
      if (i % 5 == 1) idle();
    end
    repeat (3) idle();
    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end
endmodule